// File: doc/BRIEF.md
# PCI Error Capture and Interrupt Aggregator

This block sits beside a PCI bus interface and keeps a record of bus errors in one 32-bit status and control word. The protocol engine reports each failure as a single-cycle strobe. The strobe kinds are master abort, target abort, other fatal conditions, a parity fault found on received data, and a parity fault reported by a remote target. With each strobe the engine also gives the direction of the transfer, whether the local device was the target, and address bits [35:32] of the failing access. The block raises sticky flags for these errors. It keeps the transfer details of the first error only. It flags repeat errors separately.

The block also watches the arbiter. When a master is granted the bus, a counter starts. If that master neither starts a transaction nor withdraws its request within a fixed budget of 16 cycles, a bad-master flag is raised. Six enable bits choose which status conditions drive the single interrupt line to the system interrupt controller. Software uses a plain write strobe and an always-valid read word. There is no data stream, so the port has no handshake: every write takes effect at the next clock edge.

Top module: `pci_err_capture`

## Requirements
- R1: After reset every status flag, the address field [31:28], the enable field [13:8] and the interrupt output are 0. Bits [27:22], [15:14] and [7:0] always read 0.
- R2: A master-abort, target-abort or other-fatal strobe sets the fatal flag (bit 16) at the next clock edge.
- R3: A local-parity or remote-parity strobe sets the parity flag (bit 17) at the next clock edge.
- R4: Any error strobe, including a bad-master event, sets the multiple-error flag (bit 18) if the fatal or parity flag was already set. Strobes that all arrive in the same cycle onto clear flags do not set it.
- R5: A bus error that arrives while fatal, parity and bad-master (bit 19) are all clear is a first error. It captures the read direction into bit 20 (1 = read), the target role into bit 21 (1 = local target) and address bits [35:32] into [31:28]. Later errors change none of these fields.
- R6: Bits [21:16] are write-one-to-clear, and writing 0 to a bit leaves it unchanged. When a set event and a clear of the same flag happen in one cycle, the flag stays 1.
- R7: A write loads the enable field [13:8]. Enable bit 8+i gates status bit 16+i. The interrupt output is the OR of all enabled status bits, and it follows the flags with no extra register delay.
- R8: A status bit whose enable is 0 never raises the interrupt, but the bit is still recorded and reads back as 1.
- R9: After a grant pulse, the cycles that follow are counted. If neither the FRAME indication nor a dropped request is seen by the 16th of them, the bad-master flag is set. Activity seen in the 16th cycle prevents the flag.
- R10: Activity on FRAME or a dropped request stops the grant watchdog. A new grant pulse restarts its count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_mabort | input | 1 | Master abort strobe |
| ev_tabort | input | 1 | Target abort strobe |
| ev_fatal_misc | input | 1 | Other fatal condition strobe |
| ev_par_local | input | 1 | Parity error detected on received data |
| ev_par_remote | input | 1 | Parity error reported by remote target |
| err_is_read | input | 1 | Failing access was a read |
| err_as_target | input | 1 | Local device was target of failing access |
| err_addr_hi | input | 4 | Address bits [35:32] of failing access |
| arb_grant_new | input | 1 | One-cycle pulse when a master is granted |
| mst_frame | input | 1 | Granted master drives FRAME active |
| mst_req | input | 1 | Granted master still requests the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read word |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
A wrong flag or capture state shows up in the read word at the first sample after the event's clock edge. Through the interrupt output it shows up in the same cycle, once the matching enable is set. A lost first-error capture stays visible for as long as a flag remains pending. An off-by-one in the grant watchdog shows up only at the 16-cycle boundary. It is seen in the bad-master bit two edges after the 16th cycle, so that boundary is tested from both sides.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int N_COND   = 6;
  localparam int AHI_W    = 4;
  localparam int STAT_LSB = 16;
  localparam int EN_LSB   = 8;
  localparam int AHI_LSB  = 28;

  localparam int FLG_FATAL  = 0;
  localparam int FLG_PARITY = 1;
  localparam int FLG_MULTI  = 2;
  localparam int FLG_BADMST = 3;
  localparam int FLG_READ   = 4;
  localparam int FLG_TARGET = 5;

  typedef struct packed {
    logic m_abort;
    logic t_abort;
    logic fatal_misc;
    logic par_local;
    logic par_remote;
  } bus_evt_t;
endpackage

// File: rtl/pci_gnt_watchdog.sv
module pci_gnt_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_new,
  input  logic frame_seen,
  input  logic req_active,
  output logic bad_master_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bad_q;
  logic             activity;

  assign activity = frame_seen | ~req_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (grant_new) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q) begin
        if (activity) begin
          armed_q <= 1'b0;
        end else if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          bad_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign bad_master_o = bad_q;

  AST_WD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q <= LAST)); // R9
  AST_WD_FIRE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> $past(armed_q)); // R9
  AST_WD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !grant_new && activity) |=> (!armed_q && !bad_q)); // R10
  AST_WD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    grant_new |=> (armed_q && cnt_q == '0)); // R10
endmodule

// File: rtl/pci_err_flags.sv
module pci_err_flags
  import pci_err_pkg::*;
#(
  parameter int AW = AHI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_evt_t            evt,
  input  logic                bm_evt,
  input  logic                err_is_read,
  input  logic                err_as_target,
  input  logic [AW-1:0]       err_addr_hi,
  input  logic [N_COND-1:0]   clr_mask,
  output logic [N_COND-1:0]   stat_o,
  output logic [AW-1:0]       addr_hi_o
);
  logic [N_COND-1:0] stat_q, stat_d;
  logic [AW-1:0]     ahi_q;
  logic              fatal_evt, par_evt, bus_err, any_err, pending, first;

  assign fatal_evt = evt.m_abort | evt.t_abort | evt.fatal_misc;
  assign par_evt   = evt.par_local | evt.par_remote;
  assign bus_err   = fatal_evt | par_evt;
  assign any_err   = bus_err | bm_evt;
  assign pending   = stat_q[FLG_FATAL] | stat_q[FLG_PARITY] | stat_q[FLG_BADMST];
  assign first     = bus_err & ~pending;

  always_comb begin
    stat_d = stat_q & ~clr_mask;
    if (fatal_evt) stat_d[FLG_FATAL]  = 1'b1;
    if (par_evt)   stat_d[FLG_PARITY] = 1'b1;
    if (bm_evt)    stat_d[FLG_BADMST] = 1'b1;
    if (any_err && (stat_q[FLG_FATAL] || stat_q[FLG_PARITY]))
      stat_d[FLG_MULTI] = 1'b1;
    if (first) begin
      stat_d[FLG_READ]   = err_is_read;
      stat_d[FLG_TARGET] = err_as_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ahi_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (first) ahi_q <= err_addr_hi;
    end
  end

  assign stat_o    = stat_q;
  assign addr_hi_o = ahi_q;

  AST_FATAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.m_abort || evt.t_abort || evt.fatal_misc) |=> stat_q[FLG_FATAL]); // R2
  AST_PARITY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.par_local || evt.par_remote) |=> stat_q[FLG_PARITY]); // R3
  AST_MULTI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[FLG_MULTI]) |-> $past(stat_q[FLG_FATAL] || stat_q[FLG_PARITY])); // R4
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pending) |-> (ahi_q == $past(ahi_q))); // R5
  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]))); // R6
endmodule

// File: rtl/pci_err_irq.sv
module pci_err_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] stat,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = en_q[i] & stat[i];
  end

  assign irq_o = |gated;
  assign en_o  = en_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq_o); // R7
endmodule

// File: rtl/pci_err_capture.sv
module pci_err_capture
  import pci_err_pkg::*;
#(
  parameter int WD_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_mabort,
  input  logic        ev_tabort,
  input  logic        ev_fatal_misc,
  input  logic        ev_par_local,
  input  logic        ev_par_remote,
  input  logic        err_is_read,
  input  logic        err_as_target,
  input  logic [3:0]  err_addr_hi,
  input  logic        arb_grant_new,
  input  logic        mst_frame,
  input  logic        mst_req,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  bus_evt_t          evt;
  logic              bm_evt;
  logic [N_COND-1:0] stat, en, clr_mask;
  logic [AHI_W-1:0]  ahi;
  logic              unused_wbits;

  assign evt = '{m_abort: ev_mabort, t_abort: ev_tabort, fatal_misc: ev_fatal_misc,
                 par_local: ev_par_local, par_remote: ev_par_remote};
  assign clr_mask = reg_wr ? reg_wdata[STAT_LSB +: N_COND] : '0;
  assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[15:14], reg_wdata[7:0]};

  pci_gnt_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .grant_new(arb_grant_new),
    .frame_seen(mst_frame), .req_active(mst_req), .bad_master_o(bm_evt)
  );

  pci_err_flags #(.AW(AHI_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .bm_evt(bm_evt),
    .err_is_read(err_is_read), .err_as_target(err_as_target),
    .err_addr_hi(err_addr_hi), .clr_mask(clr_mask),
    .stat_o(stat), .addr_hi_o(ahi)
  );

  pci_err_irq #(.N(N_COND)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(reg_wr),
    .en_wdata(reg_wdata[EN_LSB +: N_COND]), .stat(stat),
    .en_o(en), .irq_o(irq_o)
  );

  assign reg_rdata = {ahi, 6'b0, stat, 2'b0, en, 8'b0};

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[27:22] == '0 && reg_rdata[15:14] == '0 && reg_rdata[7:0] == '0)); // R1
endmodule

// File: tb/pci_err_capture_tb.sv
`timescale 1ns/1ps
module pci_err_capture_tb_top;
  logic clk = 0, rst_n = 0;
  logic ev_mabort = 0, ev_tabort = 0, ev_fatal_misc = 0, ev_par_local = 0, ev_par_remote = 0;
  logic err_is_read = 0, err_as_target = 0;
  logic [3:0] err_addr_hi = 0;
  logic arb_grant_new = 0, mst_frame = 0, mst_req = 1;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_err_capture dut_i (.*);

  // entry: {exp_addr, exp_stat[5:0], addr, tgt, rd, ev[4:0]}; ev bits: 0 mabort,1 tabort,2 misc,3 par_local,4 par_remote
  localparam logic [20:0] VEC [7] = '{
    {4'h5, 6'b010001, 4'h5, 1'b0, 1'b1, 5'b00001},
    {4'hA, 6'b100001, 4'hA, 1'b1, 1'b0, 5'b00010},
    {4'hF, 6'b110001, 4'hF, 1'b1, 1'b1, 5'b00100},
    {4'h3, 6'b000010, 4'h3, 1'b0, 1'b0, 5'b01000},
    {4'h9, 6'b010010, 4'h9, 1'b0, 1'b1, 5'b10000},
    {4'hC, 6'b100011, 4'hC, 1'b1, 1'b0, 5'b01001},
    {4'hC, 6'b000000, 4'h7, 1'b0, 1'b0, 5'b00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic evt(input logic [4:0] e, input logic rd, input logic tg, input logic [3:0] a);
    {ev_par_remote, ev_par_local, ev_fatal_misc, ev_tabort, ev_mabort} = e;
    err_is_read = rd; err_as_target = tg; err_addr_hi = a;
    @(negedge clk);
    {ev_par_remote, ev_par_local, ev_fatal_misc, ev_tabort, ev_mabort} = 0;
  endtask

  task automatic grant_run(input int idle, input bit use_frame);
    arb_grant_new = 1;
    @(negedge clk);
    arb_grant_new = 0;
    repeat (idle) @(negedge clk);
    if (use_frame) mst_frame = 1; else mst_req = 0;
    @(negedge clk);
    mst_frame = 0; mst_req = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 7; i++) begin
      wr(32'h003F_0000);
      evt(VEC[i][4:0], VEC[i][5], VEC[i][6], VEC[i][10:7]);
      chk($sformatf("R2/R3/R5 vec%0d status", i), {26'b0, reg_rdata[21:16]}, {26'b0, VEC[i][16:11]});
      chk($sformatf("R5 vec%0d addr", i), {28'b0, reg_rdata[31:28]}, {28'b0, VEC[i][20:17]});
    end

    // R4 multi + R5 no overwrite
    wr(32'h003F_0000);
    evt(5'b00001, 1, 0, 4'h2);
    evt(5'b10000, 0, 1, 4'h8);
    chk("R4 multi set", {26'b0, reg_rdata[21:16]}, 32'h17);
    chk("R5 first capture kept", {28'b0, reg_rdata[31:28]}, 32'h2);

    // R6 write-one-to-clear
    wr(32'h0001_0000);
    chk("R6 clear fatal only", {26'b0, reg_rdata[21:16]}, 32'h16);
    wr(32'h0);
    chk("R6 zero write no effect", {26'b0, reg_rdata[21:16]}, 32'h16);
    reg_wr = 1; reg_wdata = 32'h0001_0000; ev_mabort = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; ev_mabort = 0;
    chk("R6 set wins over clear", {31'b0, reg_rdata[16]}, 32'h1);

    // R7 / R8 interrupts: flags now fatal, parity, multi, read
    wr(32'h0023_0200); // clear fatal, parity... keep multi? clears bits 16,17,21; enable parity (bit 9)
    chk("R8 parity disabled-by-clear gives no irq", {31'b0, irq_o}, 32'h0);
    evt(5'b01000, 0, 0, 4'h1);
    chk("R7 enabled parity raises irq", {31'b0, irq_o}, 32'h1);
    chk("R7 enable readback", {26'b0, reg_rdata[13:8]}, 32'h02);
    wr(32'h0000_0100);
    chk("R8 masked parity no irq", {31'b0, irq_o}, 32'h0);
    chk("R8 parity still recorded", {31'b0, reg_rdata[17]}, 32'h1);

    // R9 / R10 watchdog
    wr(32'h003F_0000);
    grant_run(15, 1);
    chk("R9 frame in 16th cycle no bad master", {31'b0, reg_rdata[19]}, 32'h0);
    grant_run(16, 1);
    chk("R9 no start by 16th cycle flags bad master", {31'b0, reg_rdata[19]}, 32'h1);
    wr(32'h0000_0800);
    chk("R9 bad master irq when enabled", {31'b0, irq_o}, 32'h1);
    wr(32'h003F_0000);
    grant_run(5, 0);
    chk("R10 request drop stops watchdog", {31'b0, reg_rdata[19]}, 32'h0);
    arb_grant_new = 1; @(negedge clk); arb_grant_new = 0;
    repeat (10) @(negedge clk);
    grant_run(10, 1);
    chk("R10 regrant restarts count", {31'b0, reg_rdata[19]}, 32'h0);
    chk("R1 reserved bits zero", reg_rdata & 32'h0FC0_C0FF, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule